// File: doc/BRIEF.md
# Dual-Speed Peripheral Clock-Enable Generator

This block turns the oscillator clock into one-cycle enable strobes for a CPU core and six peripherals: three timers, a serial port, a counter array and a watchdog. It does not gate clocks. Every consumer runs on the oscillator clock and advances only in cycles where its enable is high. One global bit chooses between a standard rate, with one enable every 12 oscillator cycles, and a fast rate, with one enable every 6 cycles. Six per-peripheral bits can hold a single peripheral at the slower rate, but only while the global fast bit is set.

The seven control bits live in an 8-bit register on a simple special-function-register bus. The bus has an address, write data, a write strobe and combinational read data. At reset the global bit is loaded from a hardware configuration input. A single free-running modulo-12 counter feeds all outputs. This keeps every strobe phase-aligned, and a register change never restarts the count.

Top module: `dual_rate_clken`

## Requirements
- R1: While `rst` is high, all enables are low. After reset the register reads `{7'b0, boot_fast}`, with bits 7..1 zero and bit 0 equal to the configuration input sampled during reset.
- R2: The register responds only at address 0x8F. A write with `sfr_we` high at that address updates it on the next clock edge. A read at 0x8F returns its value. Writes to any other address change nothing, and reads there return 0x00.
- R3: Bit 7 is reserved. Writes to it are ignored and it always reads 0.
- R4: With bit 0 clear, `cpu_en` and all six `per_en` bits pulse every 12 cycles, together, whatever bits 6..1 hold. Those bits are still stored and read back unchanged.
- R5: With bit 0 set, `cpu_en` pulses every 6 cycles.
- R6: With bit 0 set, `per_en[i]` is driven by register bit i+1: timer 0 = bit 1, timer 1 = bit 2, timer 2 = bit 3, serial = bit 4, counter array = bit 5, watchdog = bit 6. A 0 gives a pulse every 6 cycles, in step with `cpu_en`. A 1 gives a pulse every 12 cycles.
- R7: Every enable is high for exactly one cycle per pulse.
- R8: All strobes are phase-aligned. No `per_en` bit is ever high in a cycle where `cpu_en` is low.
- R9: A register change takes effect without restarting the counter. Across any write, consecutive pulses on `cpu_en` are never fewer than 6 or more than 12 cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| boot_fast | input | 1 | Configuration input loaded into bit 0 during reset |
| sfr_addr | input | 8 | Register bus address |
| sfr_wdata | input | 8 | Register bus write data |
| sfr_we | input | 1 | Register bus write strobe |
| sfr_rdata | output | 8 | Register bus read data, combinational on `sfr_addr` |
| cpu_en | output | 1 | CPU machine-cycle enable |
| per_en | output | 6 | Peripheral enables: [0] timer 0, [1] timer 1, [2] timer 2, [3] serial, [4] counter array, [5] watchdog |

## Verification
The bench measures the spacing between pulses on every output. It covers standard mode with all override bits set, and fast mode with several override patterns. A swapped bit-to-peripheral mapping or an override that works in standard mode would therefore show up as a 6-cycle gap where 12 is expected. It toggles the mode at each of the twelve counter phases and watches the CPU gaps. A design that restarted its counter, or fired on both counts, would show a gap shorter than 6 or longer than 12. Reset is checked with the configuration input at both levels. Reserved-bit writes and wrong-address accesses are checked through read-back, so a design that stored bit 7 or decoded the address loosely would read back the wrong value.

// File: rtl/clken_pkg.sv
package clken_pkg;
  localparam int unsigned NUM_PERIPH = 6;

  // Stored control bits: per-peripheral slow selects above the global fast bit.
  typedef struct packed {
    logic [NUM_PERIPH-1:0] per_slow;
    logic                  fast;
  } ctrl_t;
endpackage

// File: rtl/clken_cfg_reg.sv
module clken_cfg_reg
  import clken_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h8F
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              boot_fast,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              we,
  output ctrl_t             ctrl,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned CTRL_W = $bits(ctrl_t);
  localparam int unsigned PAD_W  = DATA_W - CTRL_W;

  ctrl_t ctrl_q;
  logic  hit;

  assign hit = (addr == REG_ADDR);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q.per_slow <= '0;
      ctrl_q.fast     <= boot_fast;
    end else if (we && hit) begin
      ctrl_q <= ctrl_t'(wdata[CTRL_W-1:0]);
    end
  end

  // Reserved upper bits are never stored and always read as zero.
  assign rdata = hit ? {{PAD_W{1'b0}}, ctrl_q} : '0;
  assign ctrl  = ctrl_q;
endmodule

// File: rtl/clken_phase_ctr.sv
module clken_phase_ctr #(
  parameter int unsigned PERIOD = 12
) (
  input  logic clk,
  input  logic rst,
  output logic tick_full,
  output logic tick_half
);
  localparam int unsigned CNT_W = $clog2(PERIOD);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);
  localparam logic [CNT_W-1:0] MID  = CNT_W'(PERIOD / 2 - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

  assign tick_full = (cnt_q == LAST);
  assign tick_half = (cnt_q == MID);
endmodule

// File: rtl/clken_strobe.sv
module clken_strobe (
  input  logic clk,
  input  logic rst,
  input  logic fast_mode,
  input  logic hold_slow,
  input  logic tick_full,
  input  logic tick_half,
  output logic en
);
  logic en_q;

  always_ff @(posedge clk) begin
    if (rst) en_q <= 1'b0;
    else     en_q <= tick_full | (fast_mode & ~hold_slow & tick_half);
  end

  assign en = en_q;
endmodule

// File: rtl/dual_rate_clken.sv
module dual_rate_clken
  import clken_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned DATA_W      = 8,
  parameter logic [ADDR_W-1:0] CFG_ADDR = 8'h8F,
  parameter int unsigned SLOW_PERIOD = 12
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  boot_fast,
  input  logic [ADDR_W-1:0]     sfr_addr,
  input  logic [DATA_W-1:0]     sfr_wdata,
  input  logic                  sfr_we,
  output logic [DATA_W-1:0]     sfr_rdata,
  output logic                  cpu_en,
  output logic [NUM_PERIPH-1:0] per_en
);
  ctrl_t ctrl_w;
  logic  tick_full, tick_half;

  clken_cfg_reg #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_ADDR(CFG_ADDR)
  ) cfg_i (
    .clk(clk), .rst(rst), .boot_fast(boot_fast),
    .addr(sfr_addr), .wdata(sfr_wdata), .we(sfr_we),
    .ctrl(ctrl_w), .rdata(sfr_rdata)
  );

  clken_phase_ctr #(.PERIOD(SLOW_PERIOD)) ctr_i (
    .clk(clk), .rst(rst), .tick_full(tick_full), .tick_half(tick_half)
  );

  clken_strobe cpu_strb_i (
    .clk(clk), .rst(rst), .fast_mode(ctrl_w.fast), .hold_slow(1'b0),
    .tick_full(tick_full), .tick_half(tick_half), .en(cpu_en)
  );

  for (genvar i = 0; i < NUM_PERIPH; i++) begin : g_per
    clken_strobe per_strb_i (
      .clk(clk), .rst(rst), .fast_mode(ctrl_w.fast), .hold_slow(ctrl_w.per_slow[i]),
      .tick_full(tick_full), .tick_half(tick_half), .en(per_en[i])
    );
  end
endmodule

// File: rtl/dual_rate_clken_chk.sv
module dual_rate_clken_chk #(
  parameter int unsigned NUM_PERIPH = 6
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  boot_fast,
  input logic [NUM_PERIPH:0]   ctrl_bits,
  input logic                  cpu_en,
  input logic [NUM_PERIPH-1:0] per_en
);
  logic [4:0] gap_q;
  logic       seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (cpu_en) begin
      gap_q  <= 5'd1;
      seen_q <= 1'b1;
    end else if (gap_q != 5'd31) begin
      gap_q <= gap_q + 5'd1;
    end
  end

  // R1: reset loads the configuration input into bit 0 and clears the rest
  a_r1_reset_value: assert property (@(posedge clk)
    rst |=> (ctrl_bits == {{NUM_PERIPH{1'b0}}, $past(boot_fast)}));

  // R1: no strobes while in reset
  a_r1_quiet_reset: assert property (@(posedge clk)
    rst |=> (!cpu_en && per_en == '0));

  // R7: a CPU strobe lasts one cycle
  a_r7_cpu_single: assert property (@(posedge clk) disable iff (rst)
    cpu_en |=> !cpu_en);

  // R8: peripheral strobes only coincide with CPU strobes
  a_r8_aligned: assert property (@(posedge clk) disable iff (rst)
    (per_en != '0) |-> cpu_en);

  // R4: standard mode makes every output identical
  a_r4_std_uniform: assert property (@(posedge clk) disable iff (rst)
    !$past(ctrl_bits[0]) |-> (per_en == {NUM_PERIPH{cpu_en}}));

  // R9: CPU strobe spacing stays within 6..12 cycles, even across writes
  a_r9_gap_bounds: assert property (@(posedge clk) disable iff (rst)
    (cpu_en && seen_q) |-> (gap_q >= 5'd6 && gap_q <= 5'd12));

  for (genvar i = 0; i < NUM_PERIPH; i++) begin : g_chk
    // R7: each peripheral strobe lasts one cycle
    a_r7_per_single: assert property (@(posedge clk) disable iff (rst)
      per_en[i] |=> !per_en[i]);
    // R6: a fast-rate peripheral in fast mode follows the CPU strobe
    a_r6_fast_follow: assert property (@(posedge clk) disable iff (rst)
      ($past(ctrl_bits[0]) && !$past(ctrl_bits[i+1])) |-> (per_en[i] == cpu_en));
  end
endmodule

bind dual_rate_clken dual_rate_clken_chk #(.NUM_PERIPH(clken_pkg::NUM_PERIPH)) chk_i (
  .clk(clk), .rst(rst), .boot_fast(boot_fast), .ctrl_bits(ctrl_w),
  .cpu_en(cpu_en), .per_en(per_en)
);

// File: tb/dual_rate_clken_tb_top.sv
`timescale 1ns/1ps
module dual_rate_clken_tb_top;
  logic       clk = 1'b0;
  logic       rst, boot_fast, sfr_we;
  logic [7:0] sfr_addr, sfr_wdata, sfr_rdata;
  logic       cpu_en;
  logic [5:0] per_en;

  always #2 clk = ~clk;

  dual_rate_clken dut_i (
    .clk(clk), .rst(rst), .boot_fast(boot_fast), .sfr_addr(sfr_addr),
    .sfr_wdata(sfr_wdata), .sfr_we(sfr_we), .sfr_rdata(sfr_rdata),
    .cpu_en(cpu_en), .per_en(per_en)
  );

  typedef struct {
    int    idx;
    int    gap;
    string req;
  } exp_t;

  exp_t sb_q[$];
  int   checks = 0;
  int   errors = 0;
  bit   done   = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic sel(input int idx);
    return (idx == 0) ? cpu_en : per_en[idx-1];
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    check(0, "WDOG", "watchdog expired", 0, 1);
    finish_run();
  end

  // Monitor: pops expected gaps and measures them on the named output
  initial begin
    forever begin
      @(negedge clk);
      if (sb_q.size() != 0) begin
        exp_t it;
        int   gap;
        int   guard;
        it    = sb_q[0];
        guard = 0;
        while (!sel(it.idx) && guard < 40) begin
          @(negedge clk);
          guard++;
        end
        @(negedge clk);
        check(!sel(it.idx), "R7", $sformatf("pulse width out %0d", it.idx), sel(it.idx), 0);
        gap = 1;
        while (!sel(it.idx) && gap < 40) begin
          @(negedge clk);
          gap++;
        end
        check(gap == it.gap, it.req, $sformatf("gap on output %0d", it.idx), gap, it.gap);
        void'(sb_q.pop_front());
      end
    end
  end

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    sfr_addr = a; sfr_wdata = d; sfr_we = 1'b1;
    @(negedge clk);
    sfr_we = 1'b0; sfr_addr = 8'h00; sfr_wdata = 8'h00;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    sfr_addr = a;
    #1 d = sfr_rdata;
    sfr_addr = 8'h00;
  endtask

  task automatic apply_reset(input logic b);
    logic [7:0] rd;
    @(negedge clk);
    rst = 1'b1; boot_fast = b;
    repeat (3) @(negedge clk);
    check(!cpu_en && per_en == 6'd0, "R1", "enables in reset", {per_en, cpu_en}, 0);
    rst = 1'b0;
    bus_read(8'h8F, rd);
    check(rd == {7'b0, b}, "R1", "reset value", rd, {7'b0, b});
  endtask

  // Driver: program a configuration and queue the expected spacing per output
  task automatic run_cfg(input logic [7:0] val);
    logic [7:0] rd;
    bus_write(8'h8F, val);
    bus_read(8'h8F, rd);
    check(rd == (val & 8'h7F), "R4", "read-back of stored bits", rd, val & 8'h7F);
    for (int i = 0; i < 7; i++) begin
      exp_t it;
      it.idx = i;
      if (!val[0]) begin
        it.gap = 12; it.req = "R4";
      end else if (i == 0) begin
        it.gap = 6;  it.req = "R5";
      end else begin
        it.gap = val[i] ? 12 : 6; it.req = "R6";
      end
      sb_q.push_back(it);
    end
    while (sb_q.size() != 0) @(negedge clk);
  endtask

  task automatic align_window(input logic [7:0] val);
    int bad = 0;
    int mism = 0;
    for (int c = 0; c < 36; c++) begin
      @(negedge clk);
      if (per_en != 6'd0 && !cpu_en) bad++;
      for (int i = 0; i < 6; i++)
        if (val[0] && !val[i+1] && per_en[i] != cpu_en) mism++;
    end
    check(bad == 0, "R8", "peripheral strobe without CPU strobe", bad, 0);
    check(mism == 0, "R6", "fast peripheral out of step with CPU", mism, 0);
  endtask

  task automatic switch_gaps(input int k, input logic [7:0] from_v, input logic [7:0] to_v);
    int last = -1;
    int mn = 100;
    int mx = 0;
    bus_write(8'h8F, from_v);
    repeat (k) @(negedge clk);
    fork
      bus_write(8'h8F, to_v);
      for (int c = 0; c < 40; c++) begin
        @(negedge clk);
        if (cpu_en) begin
          if (last >= 0) begin
            if (c - last < mn) mn = c - last;
            if (c - last > mx) mx = c - last;
          end
          last = c;
        end
      end
    join
    check(mn >= 6 && mx <= 12, "R9", $sformatf("gap bounds at phase %0d (min)", k), mn, 6);
  endtask

  initial begin
    logic [7:0] rd;
    rst = 1'b1; boot_fast = 1'b0; sfr_we = 1'b0; sfr_addr = 8'h00; sfr_wdata = 8'h00;

    apply_reset(1'b1);
    apply_reset(1'b0);

    // R2: wrong address neither writes nor reads
    bus_write(8'h8E, 8'h55);
    bus_read(8'h8F, rd);
    check(rd == 8'h00, "R2", "write at other address", rd, 0);
    bus_read(8'h8E, rd);
    check(rd == 8'h00, "R2", "read at other address", rd, 0);
    bus_write(8'h8F, 8'h2B);
    bus_read(8'h8F, rd);
    check(rd == 8'h2B, "R2", "write at register address", rd, 8'h2B);

    // R3: reserved bit
    bus_write(8'h8F, 8'h80);
    bus_read(8'h8F, rd);
    check(rd == 8'h00, "R3", "bit 7 alone", rd, 0);
    bus_write(8'h8F, 8'hFF);
    bus_read(8'h8F, rd);
    check(rd == 8'h7F, "R3", "all ones", rd, 8'h7F);

    run_cfg(8'h00);
    run_cfg(8'h7E);
    align_window(8'h7E);
    run_cfg(8'h01);
    align_window(8'h01);
    run_cfg(8'h7F);
    align_window(8'h7F);
    run_cfg(8'h2B);
    align_window(8'h2B);
    run_cfg(8'h55);
    align_window(8'h55);

    for (int k = 0; k < 12; k++) begin
      switch_gaps(k, 8'h00, 8'h01);
      switch_gaps(k, 8'h01, 8'h00);
    end

    finish_run();
  end
endmodule